// File: doc/BRIEF.md
# Configurable Logic Tile

This block is one programmable logic cell. A 22-bit configuration word, written through a load strobe, sets what the cell computes and how it stores the result. Two 8-entry truth tables are each addressed by the three low data inputs. The fourth data input picks one of the two table outputs. Between them the tables can realise any combinational function of four inputs.

The selected function value feeds one storage bit. Several things about that bit are chosen at run time by control fields:
- the clock edge that updates it,
- the active levels of the enable and set/reset inputs,
- whether set/reset drives it to 1 or to 0,
- whether the enable is honoured at all.

A last field chooses whether the cell output shows the function value directly or the stored bit. A fabric-level model instantiates one cell per logic site. It drives each cell's configuration word and connects its four data inputs and its controls.

Top module: `logic_tile`

## Requirements
- R1: A synchronous active-high reset clears the configuration word to all zeros and clears the storage bit to 0. After reset the output is 0. A registered configuration loaded while the enable is held inactive therefore also shows 0.
- R2: In combinational mode (word bit 20 = 0), the output equals word bit `din`, with `din` read as an unsigned number 0..15. Bits 7:0 form the table used when din[3]=0, and bits 15:8 form the table used when din[3]=1. Each table is indexed by din[2:0].
- R3: The configuration word is captured only at a rising clock edge with `cfg_we` high, and it governs behaviour from that edge on. While `cfg_we` is low, changes on `cfg_word` have no effect.
- R4: In registered mode (bit 20 = 1) with rising-edge clocking (bit 16 = 0), the output changes only at rising edges. At each such edge with the enable active and set/reset inactive, the output takes the function value.
- R5: With bit 16 = 1, the storage bit updates at falling edges only, and rising edges leave it unchanged.
- R6: The enable is active high when bit 17 = 0 and active low when bit 17 = 1. While the enable is inactive and set/reset is inactive, the storage bit holds its value.
- R7: When bit 21 = 1, the enable input is ignored and the storage bit updates at every selected edge.
- R8: Set/reset is synchronous to the selected edge and wins over the enable. It is active high when bit 18 = 0 and active low when bit 18 = 1. While active, it loads 1 if bit 19 = 1 and 0 if bit 19 = 0.
- R9: Changing the selected clock edge at run time keeps the stored value. The registered output does not change across the switch unless an enabled update or set/reset occurs at an edge of the new kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used internally |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_word | input | 22 | Configuration word (function bits and control fields) |
| din | input | 4 | Function inputs |
| ce | input | 1 | Clock enable, level set by configuration |
| sr | input | 1 | Set/reset, level and value set by configuration |
| tile_out | output | 1 | Combinational or registered result |

## Verification
The bench walks every one of the 16 function indices under two unrelated truth tables. A swapped table half or reversed entry order would show as a wrong bit at some index.

Falling-edge mode is checked on both sides of each edge. A design that still updated on the rising edge would show a value one half cycle early or late. Enable and set/reset are checked in both polarities, with set/reset asserted while the enable is also active, so an inverted level or a reversed priority shows up.

The edge-switch scenario samples the output in each half cycle around a mode change. A design that lost or glitched the stored bit when moving between its two edge paths would show a momentary wrong value.

// File: rtl/tile_pkg.sv
package tile_pkg;

    localparam int LUT_INPUTS = 3;
    localparam int LUT_DEPTH  = 1 << LUT_INPUTS;
    localparam int NUM_LUTS   = 2;
    localparam int DIN_W      = LUT_INPUTS + $clog2(NUM_LUTS);
    localparam int FUNC_W     = LUT_DEPTH * NUM_LUTS;
    localparam int CTRL_W     = 6;
    localparam int CFG_W      = FUNC_W + CTRL_W;

    typedef struct packed {
        logic ce_ignore;   // bit 21
        logic registered;  // bit 20
        logic sr_set;      // bit 19
        logic sr_low;      // bit 18
        logic ce_low;      // bit 17
        logic fall_edge;   // bit 16
    } tile_ctrl_t;

    typedef struct packed {
        tile_ctrl_t              ctrl;
        logic [FUNC_W-1:0]       func;
    } tile_cfg_t;

    function automatic logic level_active(input logic pin, input logic active_low);
        return pin ^ active_low;
    endfunction

endpackage

// File: rtl/tile_cfg_reg.sv
module tile_cfg_reg
    import tile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] word,
    output tile_cfg_t        cfg
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (we)
            cfg <= tile_cfg_t'(word);
    end

    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg));

    // R3
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg == tile_cfg_t'($past(word))));

endmodule

// File: rtl/tile_lut_bank.sv
module tile_lut_bank
    import tile_pkg::*;
(
    input  logic [FUNC_W-1:0] func,
    input  logic [DIN_W-1:0]  din,
    output logic              f
);

    logic [NUM_LUTS-1:0]   lut_out;
    logic [LUT_INPUTS-1:0] addr;

    assign addr = din[LUT_INPUTS-1:0];

    for (genvar g = 0; g < NUM_LUTS; g++) begin : g_lut
        logic [LUT_DEPTH-1:0] table_bits;
        assign table_bits = func[g*LUT_DEPTH +: LUT_DEPTH];
        assign lut_out[g] = table_bits[addr];
    end

    assign f = lut_out[din[DIN_W-1:LUT_INPUTS]];

endmodule

// File: rtl/tile_store.sv
module tile_store
    import tile_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic d,
    input  logic ce,
    input  logic sr,
    input  logic fall_edge,
    input  logic ce_low,
    input  logic ce_ignore,
    input  logic sr_low,
    input  logic sr_set,
    output logic q
);

    logic q_rise, q_fall, sel_fall;
    logic sr_act, en_act, nxt;

    assign sr_act = level_active(sr, sr_low);
    assign en_act = ce_ignore | level_active(ce, ce_low);
    assign q      = sel_fall ? q_fall : q_rise;
    assign nxt    = sr_act ? sr_set : (en_act ? d : q);

    // Rising-edge path: active in rise mode, tracks visible value otherwise
    always_ff @(posedge clk) begin
        if (rst)
            q_rise <= 1'b0;
        else if (!fall_edge)
            q_rise <= nxt;
        else
            q_rise <= q;
    end

    // Falling-edge path and output select, both switched on falling edges
    always_ff @(negedge clk) begin
        if (rst) begin
            q_fall   <= 1'b0;
            sel_fall <= 1'b0;
        end else begin
            q_fall   <= fall_edge ? nxt : q;
            sel_fall <= fall_edge;
        end
    end

    // R8
    rise_sr_chk: assert property (@(posedge clk) disable iff (rst)
        (!fall_edge && sr_act) |=> (q_rise == $past(sr_set)));

    // R4
    rise_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!fall_edge && !sr_act && en_act) |=> (q_rise == $past(d)));

    // R6
    rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fall_edge && !sr_act && !en_act && !sel_fall) |=> (q_rise == $past(q_rise)));

    // R8
    fall_sr_chk: assert property (@(negedge clk) disable iff (rst)
        (fall_edge && sr_act) |=> (q_fall == $past(sr_set)));

    // R9
    fall_track_chk: assert property (@(negedge clk) disable iff (rst)
        (!fall_edge) |=> (q_fall == $past(q)));

endmodule

// File: rtl/logic_tile.sv
module logic_tile
    import tile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [DIN_W-1:0] din,
    input  logic             ce,
    input  logic             sr,
    output logic             tile_out
);

    tile_cfg_t cfg;
    logic      func_val;
    logic      stored;

    tile_cfg_reg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .word (cfg_word),
        .cfg  (cfg)
    );

    tile_lut_bank u_lut (
        .func (cfg.func),
        .din  (din),
        .f    (func_val)
    );

    tile_store u_store (
        .clk       (clk),
        .rst       (rst),
        .d         (func_val),
        .ce        (ce),
        .sr        (sr),
        .fall_edge (cfg.ctrl.fall_edge),
        .ce_low    (cfg.ctrl.ce_low),
        .ce_ignore (cfg.ctrl.ce_ignore),
        .sr_low    (cfg.ctrl.sr_low),
        .sr_set    (cfg.ctrl.sr_set),
        .q         (stored)
    );

    assign tile_out = cfg.ctrl.registered ? stored : func_val;

    // R1
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (tile_out == 1'b0));

endmodule

// File: tb/logic_tile_bench.sv
module logic_tile_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [21:0] cfg_word = '0;
    logic [3:0]  din = '0;
    logic        ce = 1'b0;
    logic        sr = 1'b0;
    logic        tile_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic_tile u_logic_tile (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_word (cfg_word),
        .din      (din),
        .ce       (ce),
        .sr       (sr),
        .tile_out (tile_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [21:0] mk(input logic [15:0] lut, input bit fall,
                                       input bit ce_low, input bit sr_low, input bit sr_set,
                                       input bit reg_out, input bit ce_ign);
        return {ce_ign, reg_out, sr_set, sr_low, ce_low, fall, lut};
    endfunction

    task automatic check(input string req, input logic exp);
        checks++;
        if (tile_out !== exp) begin
            errors++;
            $display("FAIL %s: tile_out=%b expected=%b at %0t", req, tile_out, exp, $time);
        end
    endtask

    // one rising edge, then settle 2 time units later (before the falling edge)
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic write_cfg(input logic [21:0] w);
        cfg_word = w;
        cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        #1 check("R1 comb after reset", 1'b0);
        write_cfg(mk(16'hFFFF, 0, 0, 0, 0, 1, 0));
        step();
        check("R1 stored bit cleared", 1'b0);
    endtask

    task automatic t_lut();
        logic [15:0] pats [2] = '{16'hA5C3, 16'h8117};
        foreach (pats[p]) begin
            write_cfg(mk(pats[p], 0, 0, 0, 0, 0, 0));
            for (int i = 0; i < 16; i++) begin
                din = 4'(i);
                #1 check("R2 table lookup", pats[p][i]);
            end
        end
    endtask

    task automatic t_cfg_ignore();
        write_cfg(mk(16'hFFFF, 0, 0, 0, 0, 0, 0));
        cfg_word = mk(16'h0000, 0, 0, 0, 0, 0, 0);
        din = 4'd5;
        step(); step();
        check("R3 word ignored without strobe", 1'b1);
        write_cfg(cfg_word);
        #1 check("R3 word loaded with strobe", 1'b0);
    endtask

    task automatic t_rise();
        din = 4'd0;
        write_cfg(mk(16'hAAAA, 0, 0, 0, 0, 1, 1));
        step();
        check("R4 registered zero", 1'b0);
        din = 4'd1;
        #1 check("R4 no combinational path", 1'b0);
        step();
        check("R4 captured at rising edge", 1'b1);
        din = 4'd2;
        step();
        check("R4 captured zero", 1'b0);
    endtask

    task automatic t_fall();
        din = 4'd0;
        write_cfg(mk(16'hAAAA, 1, 0, 0, 0, 1, 1));
        din = 4'd1;
        #1 check("R5 before falling edge", 1'b0);
        #4 check("R5 after falling edge", 1'b1);
        din = 4'd0;
        @(posedge clk);
        #1 check("R5 rising edge ignored", 1'b1);
        @(negedge clk);
        #1 check("R5 next falling edge", 1'b0);
        step();
    endtask

    task automatic t_ce();
        ce = 1'b0;
        din = 4'd0;
        write_cfg(mk(16'hAAAA, 0, 0, 0, 0, 1, 0));
        din = 4'd1; ce = 1'b1;
        step();
        check("R6 active-high enable loads", 1'b1);
        din = 4'd0; ce = 1'b0;
        step();
        check("R6 inactive enable holds", 1'b1);
        ce = 1'b1;
        step();
        check("R6 enable loads zero", 1'b0);
        din = 4'd1;
        write_cfg(mk(16'hAAAA, 0, 1, 0, 0, 1, 0));
        check("R6 loaded at config edge", 1'b1);
        din = 4'd0; ce = 1'b1;
        step();
        check("R6 active-low enable held high", 1'b1);
        ce = 1'b0;
        step();
        check("R6 active-low enable loads", 1'b0);
        // R7
        write_cfg(mk(16'hAAAA, 0, 0, 0, 0, 1, 1));
        ce = 1'b0; din = 4'd1;
        step();
        check("R7 enable ignored", 1'b1);
    endtask

    task automatic t_sr();
        ce = 1'b1; sr = 1'b0;
        write_cfg(mk(16'hFFFF, 0, 0, 0, 0, 1, 0));
        step();
        check("R8 baseline load", 1'b1);
        sr = 1'b1;
        step();
        check("R8 clear wins over enable", 1'b0);
        ce = 1'b0;
        write_cfg(mk(16'h0000, 0, 0, 1, 1, 1, 0));
        sr = 1'b0;
        step();
        check("R8 active-low set", 1'b1);
        sr = 1'b1; ce = 1'b1;
        step();
        check("R8 set released, loads", 1'b0);
        // falling-edge set/reset
        ce = 1'b1; sr = 1'b1;
        write_cfg(mk(16'h0000, 1, 0, 0, 1, 1, 0));
        #4 check("R8 set at falling edge", 1'b1);
        sr = 1'b0;
        step();
    endtask

    task automatic t_switch();
        ce = 1'b1; sr = 1'b0;
        write_cfg(mk(16'hFFFF, 0, 0, 0, 0, 1, 0));
        step();
        check("R9 stored one", 1'b1);
        ce = 1'b0;
        write_cfg(mk(16'hFFFF, 1, 0, 0, 0, 1, 0));
        check("R9 right after switch", 1'b1);
        #4 check("R9 after first falling edge", 1'b1);
        step();
        check("R9 steady in fall mode", 1'b1);
        ce = 1'b1;
        write_cfg(mk(16'h0000, 1, 0, 0, 0, 1, 0));
        #1 check("R9 no early change", 1'b1);
        #3 check("R9 fall mode live", 1'b0);
        ce = 1'b0;
        write_cfg(mk(16'hFFFF, 0, 0, 0, 0, 1, 0));
        check("R9 back to rise", 1'b0);
        #4 check("R9 rise switch half cycle", 1'b0);
        step();
        check("R9 rise mode holds", 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_lut();
                t_cfg_ignore();
                t_rise();
                t_fall();
                t_ce();
                t_sr();
                t_switch();
                done = 1'b1;
            end
            begin
                #(CLK_PERIOD * 100000);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog: run hung");
                end
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule